// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block holds the interrupt enable register of a 16550/16750-class serial port and turns four pending conditions into the identification byte that software reads and into one interrupt line. The four conditions are receiver line status, received data (or character timeout), transmitter holding register empty and modem status. Other blocks produce them as levels. Each one is gated by its enable bit. The surviving source with the highest rank is encoded into the low nibble of the identification byte, and the upper bits show whether the FIFOs and the 64-entry mode are on.

The transmitter-empty condition is the only one whose pending state lives here. It becomes pending on a rising edge of the holding-register-empty status, or when its enable bit goes from 0 to 1 while the holding register is already empty. It is cleared by a write to the holding register, or by a read of the identification byte at a time when that byte reports transmitter-empty. The interrupt line is a registered copy of "something is pending". It is not gated by any modem control output. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 0x01, the enable register reads 0x00 and `irq` is 0.
- R2: A write to the enable register stores bits 3:0. Bits 7:4 are ignored and read back as 0. The bit map is: bit 0 received data/timeout, bit 1 transmitter empty, bit 2 line status, bit 3 modem status.
- R3: A source whose enable bit is 0 never appears in the identification byte and never raises `irq`.
- R4: The low nibble of the identification byte is one of these codes: 0x1 nothing pending, 0x6 line status, 0x4 received data, 0xC character timeout, 0x2 transmitter empty, 0x0 modem status. The rank from highest to lowest is line status, received data or timeout, transmitter empty, modem status.
- R5: Inside the received-data level, received data (0x4) is reported in preference to timeout (0xC) when both are pending.
- R6: Bits 7:6 of the identification byte read 11 when `fifo_en` is 1 and 00 otherwise. Bit 5 reads 1 only when both `fifo64_en` and `fifo_en` are 1. Bit 4 is always 0.
- R7: Transmitter-empty becomes pending on a 0-to-1 edge of `thr_empty`. While `thr_empty` stays high it is not armed again.
- R8: A write that changes enable bit 1 from 0 to 1 while `thr_empty` is 1 makes transmitter-empty pending at once.
- R9: A read of the identification byte that reports code 0x2 clears transmitter-empty pending. A read that reports a higher-ranked code leaves it pending.
- R10: A pulse on `thr_we` clears transmitter-empty pending. A clear has priority over a set in the same cycle.
- R11: `irq` equals the inverse of identification bit 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_we | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Enable register write data |
| iir_re | input | 1 | Read strobe for the identification byte (triggers the clear-on-read) |
| thr_we | input | 1 | Transmit holding register write strobe |
| line_stat_pend | input | 1 | Receiver line status condition (level) |
| rx_data_pend | input | 1 | Received data at trigger level (level) |
| rx_timeout_pend | input | 1 | Character timeout condition (level) |
| modem_pend | input | 1 | Modem status change condition (level) |
| thr_empty | input | 1 | Holding register empty status (level) |
| fifo_en | input | 1 | FIFOs enabled |
| fifo64_en | input | 1 | 64-entry FIFO mode selected |
| ier_rdata | output | 8 | Enable register read value |
| iir_rdata | output | 8 | Identification byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims at the rank boundaries: each source is stacked on top of the lower-ranked ones and then removed again. A wrong priority chain would report a lower code while line status is still set, or would report timeout while data is also present. For transmitter-empty it checks four things. A steady-high `thr_empty` must not re-arm the pending flag, which a level-sensitive design would do. A read that reports line status must leave transmitter-empty pending, which an unconditional clear-on-read would lose. A holding-register write must clear the flag. Enabling the interrupt must arm the flag only while the register is already empty. The bench also checks that `irq` lags the identification byte by exactly one clock, and that bit 5 stays 0 whenever the FIFOs are off.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned CODE_W  = 4;

  // enable register bit positions
  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THRE  = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  // source slots, index 0 is the highest rank
  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_RX    = 2'd1,
    SRC_THRE  = 2'd2,
    SRC_MODEM = 2'd3
  } irq_src_e;

  localparam logic [CODE_W-1:0] ID_NONE    = 4'h1;
  localparam logic [CODE_W-1:0] ID_LINE    = 4'h6;
  localparam logic [CODE_W-1:0] ID_RXDATA  = 4'h4;
  localparam logic [CODE_W-1:0] ID_TIMEOUT = 4'hC;
  localparam logic [CODE_W-1:0] ID_THRE    = 4'h2;
  localparam logic [CODE_W-1:0] ID_MODEM   = 4'h0;

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
#(
  parameter int unsigned W     = REG_W,
  parameter int unsigned EN_W  = NUM_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [EN_W-1:0] en_q,
  output logic [W-1:0]  rdata,
  output logic          thre_en_rise
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= wdata[EN_W-1:0];
  end

  always_comb begin
    rdata = '0;
    rdata[EN_W-1:0] = en_q;
  end

  assign thre_en_rise = we && wdata[EN_THRE] && !en_q[EN_THRE];

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[W-1:EN_W] == '0)); // R2

endmodule

// File: rtl/uart_thre_tracker.sv
module uart_thre_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic arm,
  input  logic thr_write,
  input  logic read_clear,
  output logic pend
);

  logic empty_d;
  logic edge_set;

  assign edge_set = thr_empty && !empty_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_d <= 1'b1;
      pend    <= 1'b0;
    end else begin
      empty_d <= thr_empty;
      if (thr_write || read_clear)           pend <= 1'b0;
      else if (edge_set || (arm && thr_empty)) pend <= 1'b1;
    end
  end

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> !pend); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    read_clear |=> !pend); // R9

  AST_SET_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(thr_empty)); // R7

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          rx_is_data,
  output logic [N-1:0]  grant,
  output logic [CW-1:0] code
);

  logic [N-1:0] higher;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_top
        assign higher[g] = 1'b0;
      end else begin : g_rest
        assign higher[g] = higher[g-1] | req[g-1];
      end
      assign grant[g] = req[g] & ~higher[g];
    end
  endgenerate

  always_comb begin
    code = ID_NONE;
    unique case (1'b1)
      grant[SRC_LINE]:  code = ID_LINE;
      grant[SRC_RX]:    code = rx_is_data ? ID_RXDATA : ID_TIMEOUT;
      grant[SRC_THRE]:  code = ID_THRE;
      grant[SRC_MODEM]: code = ID_MODEM;
      default:          code = ID_NONE;
    endcase
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R4

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req[SRC_LINE] |-> (code == ID_LINE)); // R4

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (code == ID_NONE)); // R4

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  input  logic       iir_re,
  input  logic       thr_we,
  input  logic       line_stat_pend,
  input  logic       rx_data_pend,
  input  logic       rx_timeout_pend,
  input  logic       modem_pend,
  input  logic       thr_empty,
  input  logic       fifo_en,
  input  logic       fifo64_en,
  output logic [7:0] ier_rdata,
  output logic [7:0] iir_rdata,
  output logic       irq
);

  logic [NUM_SRC-1:0] en_q;
  logic               thre_arm;
  logic               thre_pend;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [CODE_W-1:0]  code;
  logic               rd_clear;

  uart_irq_enable #(.W(REG_W), .EN_W(NUM_SRC)) i_enable (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (ier_we),
    .wdata        (ier_wdata),
    .en_q         (en_q),
    .rdata        (ier_rdata),
    .thre_en_rise (thre_arm)
  );

  assign rd_clear = iir_re && grant[SRC_THRE];

  uart_thre_tracker i_thre (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_empty  (thr_empty),
    .arm        (thre_arm),
    .thr_write  (thr_we),
    .read_clear (rd_clear),
    .pend       (thre_pend)
  );

  always_comb begin
    req = '0;
    req[SRC_LINE]  = line_stat_pend & en_q[EN_LINE];
    req[SRC_RX]    = (rx_data_pend | rx_timeout_pend) & en_q[EN_RX];
    req[SRC_THRE]  = thre_pend & en_q[EN_THRE];
    req[SRC_MODEM] = modem_pend & en_q[EN_MODEM];
  end

  uart_irq_prio #(.N(NUM_SRC), .CW(CODE_W)) i_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .rx_is_data (rx_data_pend),
    .grant      (grant),
    .code       (code)
  );

  assign iir_rdata = {{2{fifo_en}}, fifo_en & fifo64_en, 1'b0, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= ~code[0];
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq); // R3

  AST_LINE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stat_pend && en_q[EN_LINE]) |=> irq); // R11

  AST_NO_BIT5_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (iir_rdata[5] == 1'b0)); // R6

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_we = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic       iir_re = 1'b0;
  logic       thr_we = 1'b0;
  logic       line_stat_pend = 1'b0;
  logic       rx_data_pend = 1'b0;
  logic       rx_timeout_pend = 1'b0;
  logic       modem_pend = 1'b0;
  logic       thr_empty = 1'b1;
  logic       fifo_en = 1'b0;
  logic       fifo64_en = 1'b0;
  logic [7:0] ier_rdata;
  logic [7:0] iir_rdata;
  logic       irq;

  always #2.5 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .iir_re(iir_re), .thr_we(thr_we), .line_stat_pend(line_stat_pend),
    .rx_data_pend(rx_data_pend), .rx_timeout_pend(rx_timeout_pend),
    .modem_pend(modem_pend), .thr_empty(thr_empty), .fifo_en(fifo_en),
    .fifo64_en(fifo64_en), .ier_rdata(ier_rdata), .iir_rdata(iir_rdata),
    .irq(irq)
  );

  typedef struct {
    logic [7:0] iir;
    logic [7:0] ier;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // monitor: pops each expectation and compares against the ports
  initial begin
    forever begin
      wait (sb.size() != 0);
      begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (iir_rdata !== e.iir || ier_rdata !== e.ier || irq !== e.irq) begin
          n_fail++;
          $display("FAIL %s: iir=%h ier=%h irq=%b expected iir=%h ier=%h irq=%b",
                   e.tag, iir_rdata, ier_rdata, irq, e.iir, e.ier, e.irq);
        end
      end
    end
  end

  task automatic expect_now(input logic [7:0] iir, input logic [7:0] ier,
                            input logic q, input string tag);
    exp_t e;
    #1;
    e.iir = iir; e.ier = ier; e.irq = q; e.tag = tag;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wdata = v; ier_we = 1'b1; step(1); ier_we = 1'b0; step(1);
  endtask

  task automatic rd_iir();
    iir_re = 1'b1; step(1); iir_re = 1'b0; step(1);
  endtask

  task automatic wr_thr();
    thr_we = 1'b1; step(1); thr_we = 1'b0; step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    expect_now(8'h01, 8'h00, 1'b0, "R1 reset state");

    line_stat_pend = 1'b1; step(2);
    expect_now(8'h01, 8'h00, 1'b0, "R3 line status masked");

    wr_ier(8'hF0);
    expect_now(8'h01, 8'h00, 1'b0, "R2 upper enable bits ignored");

    // thr_empty already high: enabling bit 1 arms transmitter-empty
    wr_ier(8'h0F);
    expect_now(8'h06, 8'h0F, 1'b1, "R2 R4 line status reported");

    rx_data_pend = 1'b1; line_stat_pend = 1'b0; step(2);
    expect_now(8'h04, 8'h0F, 1'b1, "R4 received data");

    rx_timeout_pend = 1'b1; step(2);
    expect_now(8'h04, 8'h0F, 1'b1, "R5 data wins over timeout");

    rx_data_pend = 1'b0; step(2);
    expect_now(8'h0C, 8'h0F, 1'b1, "R4 timeout code");

    rx_timeout_pend = 1'b0; modem_pend = 1'b1; step(2);
    expect_now(8'h02, 8'h0F, 1'b1, "R8 armed by enable, R4 above modem");

    rd_iir();
    expect_now(8'h00, 8'h0F, 1'b1, "R9 read reporting 0x2 clears");

    modem_pend = 1'b0; step(2);
    expect_now(8'h01, 8'h0F, 1'b0, "R4 nothing pending");

    step(4);
    expect_now(8'h01, 8'h0F, 1'b0, "R7 steady high does not re-arm");

    thr_empty = 1'b0; step(1); thr_empty = 1'b1; step(2);
    expect_now(8'h02, 8'h0F, 1'b1, "R7 rising edge sets pending");

    wr_thr();
    expect_now(8'h01, 8'h0F, 1'b0, "R10 holding write clears");

    thr_empty = 1'b0; step(1); thr_empty = 1'b1; line_stat_pend = 1'b1; step(2);
    rd_iir();
    line_stat_pend = 1'b0; step(2);
    expect_now(8'h02, 8'h0F, 1'b1, "R9 read reporting line status keeps 0x2");

    fifo_en = 1'b1; step(1);
    expect_now(8'hC2, 8'h0F, 1'b1, "R6 fifo bits");
    fifo64_en = 1'b1; step(1);
    expect_now(8'hE2, 8'h0F, 1'b1, "R6 64-entry bit");
    fifo_en = 1'b0; step(1);
    expect_now(8'h02, 8'h0F, 1'b1, "R6 64-entry bit hidden without fifo");
    fifo_en = 1'b1; rd_iir();
    expect_now(8'hE1, 8'h0F, 1'b0, "R9 clear with fifo bits set");
    fifo_en = 1'b0; fifo64_en = 1'b0;

    // clear beats set in the same cycle
    thr_empty = 1'b0; step(1);
    thr_empty = 1'b1; thr_we = 1'b1; step(1); thr_we = 1'b0; step(2);
    expect_now(8'h01, 8'h0F, 1'b0, "R10 clear over simultaneous edge");

    // masked transmitter-empty never reported
    wr_ier(8'h0D);
    thr_empty = 1'b0; step(1); thr_empty = 1'b1; step(2);
    expect_now(8'h01, 8'h0D, 1'b0, "R3 transmitter-empty masked");
    wr_thr();

    // enable while not empty: no arm
    thr_empty = 1'b0; wr_ier(8'h00); wr_ier(8'h02); step(1);
    expect_now(8'h01, 8'h02, 1'b0, "R8 no arm when holding register full");

    // irq lags by one clock
    wr_ier(8'h04);
    line_stat_pend = 1'b1;
    expect_now(8'h06, 8'h04, 1'b0, "R11 irq before clock edge");
    step(1);
    expect_now(8'h06, 8'h04, 1'b1, "R11 irq after one edge");
    line_stat_pend = 1'b0;
    expect_now(8'h01, 8'h04, 1'b1, "R11 irq still high before edge");
    step(1);
    expect_now(8'h01, 8'h04, 1'b0, "R11 irq drops after one edge");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule